// File: doc/BRIEF.md
# Translation Buffer with Cached Protection Results

This block is a small fully associative translation buffer. It holds virtual-to-physical page mappings. For each mapping it also keeps the read/write/execute permission result that the protection unit worked out when the mapping was filled. Lookups resolve in the same cycle. The block returns the physical page, and it raises an access fault when the cached permission for the requested access type is clear. On a miss it asks the page walker for a walk. Walker reads of page-table entries must be checked at supervisor privilege whatever the privilege of the access that caused them, so the block presents that privilege to the walker on a separate output.

Cached permission results go stale when protection settings change. Software resynchronises by issuing a global fence in machine mode, meaning both register-operand-is-zero flags are set. That fence clears every entry in the same cycle. Fences that are not global, or that are issued below machine mode, leave the buffer untouched.

When paging is off, or the access is made in machine mode, the buffer is bypassed. The physical page equals the virtual page, and the outcome comes from a live permission triple on a direct-check input, with no caching and no fence needed.

Top module: `prot_tlb`

## Requirements
- R1: After reset the buffer holds no mappings. A translated lookup misses: `res_valid`=0 and `walk_req`=1.
- R2: A translated lookup of a virtual page filled in an earlier cycle gives `res_valid`=1 and that fill's physical page on `res_ppn` in the same cycle. A fill becomes visible in the cycle after its strobe.
- R3: Permission triples use bit0 = read, bit1 = write and bit2 = execute. Access codes are 0 = read, 1 = write, 2 = execute and 3 = reserved. A resolved lookup sets `res_fault` when the bit for its access code is clear, and always sets it for code 3.
- R4: The buffer has 8 entries, replaced round-robin. A fill of a new page into a full buffer evicts the page that was filled first.
- R5: A fill whose virtual page is already cached overwrites that entry's physical page and permissions in place. It causes no eviction and does not move the replacement order.
- R6: A fence with `fence_priv`=3 (machine mode), `fence_rs1_zero`=1 and `fence_rs2_zero`=1 invalidates every entry. A translated lookup in the same cycle as that fence misses.
- R7: A fence missing either zero flag, or issued with `fence_priv` other than 3, has no effect on cached entries.
- R8: A fill in the same cycle as an invalidating fence is discarded.
- R9: When `paging_on`=0 or `lk_priv`=3, a lookup bypasses the buffer. It gives `res_valid`=1, `res_ppn` equal to the zero-extended virtual page, and a fault taken from `direct_perm`. It never requests a walk and leaves cached entries unchanged.
- R10: `walk_priv` is 1 (supervisor). Privilege codes are 0 = user, 1 = supervisor and 3 = machine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| paging_on | input | 1 | Page translation enabled |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page |
| lk_acc | input | 2 | Access code: 0 read, 1 write, 2 execute, 3 reserved |
| lk_priv | input | 2 | Lookup privilege: 0 user, 1 supervisor, 3 machine |
| direct_perm | input | 3 | Live permission triple used on bypass |
| fill_valid | input | 1 | Fill strobe from the page walker |
| fill_vpn | input | VPN_W | Filled virtual page |
| fill_ppn | input | PPN_W | Filled physical page |
| fill_perm | input | 3 | Protection result computed at fill |
| fence_valid | input | 1 | Fence strobe |
| fence_rs1_zero | input | 1 | First fence operand is register zero |
| fence_rs2_zero | input | 1 | Second fence operand is register zero |
| fence_priv | input | 2 | Privilege of the fence |
| res_valid | output | 1 | Lookup resolved (hit or bypass) |
| res_fault | output | 1 | Access fault for a resolved lookup |
| res_ppn | output | PPN_W | Physical page of a resolved lookup, else 0 |
| walk_req | output | 1 | Translated lookup missed; walk needed |
| walk_priv | output | 2 | Privilege for checking page-table reads |

## Verification
Directed sequences first fill eight distinct pages with differing triples. They then read each page with every access code, which separates permission bit positions from one another and from the reserved code. Refilling a cached page and then filling a ninth page tells in-place update apart from round-robin eviction. Fences are applied with each zero flag cleared, from each lower privilege, and in full machine-mode form together with a same-cycle lookup and fill, which separates a real flush from a weak fence and a dropped fill from an accepted one. A long run mixes random fills, lookups over a small page set, paging toggles, privileges and fences, and compares every cycle against a queue-based model.

// File: rtl/prot_tlb.sv
`timescale 1ns/1ps
module prot_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             paging_on,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [1:0]       lk_acc,
  input  logic [1:0]       lk_priv,
  input  logic [2:0]       direct_perm,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [2:0]       fill_perm,
  input  logic             fence_valid,
  input  logic             fence_rs1_zero,
  input  logic             fence_rs2_zero,
  input  logic [1:0]       fence_priv,
  output logic             res_valid,
  output logic             res_fault,
  output logic [PPN_W-1:0] res_ppn,
  output logic             walk_req,
  output logic [1:0]       walk_priv
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [2:0]         perm_q [ENTRIES];
  logic [IDX_W-1:0]   ptr_q;

  logic [ENTRIES-1:0] lk_match, fl_match;
  logic [PPN_W-1:0]   hit_ppn;
  logic [2:0]         hit_perm;
  logic [IDX_W-1:0]   fl_idx, wr_idx;
  logic               flush, bypass, fill_ok, lk_found, fl_hit;

  function automatic logic perm_ok(input logic [2:0] p, input logic [1:0] acc);
    case (acc)
      2'd0:    return p[0];
      2'd1:    return p[1];
      2'd2:    return p[2];
      default: return 1'b0;
    endcase
  endfunction

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign lk_match[g] = vld_q[g] && (vpn_q[g] == lk_vpn);
      assign fl_match[g] = vld_q[g] && (vpn_q[g] == fill_vpn);
    end
  endgenerate

  always_comb begin
    hit_ppn  = '0;
    hit_perm = '0;
    fl_idx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        hit_ppn  = hit_ppn | ppn_q[i];
        hit_perm = hit_perm | perm_q[i];
      end
      if (fl_match[i]) fl_idx = IDX_W'(i);
    end
  end

  assign flush    = fence_valid && fence_rs1_zero && fence_rs2_zero && (fence_priv == PRIV_M);
  assign bypass   = !paging_on || (lk_priv == PRIV_M);
  assign fill_ok  = fill_valid && !flush;
  assign lk_found = (|lk_match) && !flush;
  assign fl_hit   = |fl_match;
  assign wr_idx   = fl_hit ? fl_idx : ptr_q;

  assign res_valid = lk_valid && (bypass || lk_found);
  assign res_fault = res_valid && !perm_ok(bypass ? direct_perm : hit_perm, lk_acc);
  assign res_ppn   = !res_valid ? '0 : (bypass ? PPN_W'(lk_vpn) : hit_ppn);
  assign walk_req  = lk_valid && !bypass && !lk_found;
  assign walk_priv = PRIV_S;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (flush) begin
      vld_q <= '0;
    end else if (fill_ok) begin
      vld_q[wr_idx] <= 1'b1;
      if (!fl_hit) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ok) begin
      vpn_q[wr_idx]  <= fill_vpn;
      ppn_q[wr_idx]  <= fill_ppn;
      perm_q[wr_idx] <= fill_perm;
    end
  end

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0)); // R6
  AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && lk_valid && !bypass) |-> (!res_valid && walk_req)); // R6
  AST_FILL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && fill_valid) |=> (vld_q == '0)); // R8
  AST_WEAK_FENCE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_valid && !flush && !fill_valid) |=> (vld_q == $past(vld_q))); // R7
  AST_BYPASS_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && bypass) |-> (res_valid && !walk_req)); // R9
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R5
  AST_FILL_NO_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ok |=> ($countones(vld_q) >= $countones($past(vld_q)))); // R4
endmodule

// File: tb/tb_prot_tlb.sv
`timescale 1ns/1ps
module tb_prot_tlb;
  localparam int VPN_W = 20;
  localparam int PPN_W = 22;
  localparam int DEPTH = 8;

  logic clk = 0, rst_n = 0;
  logic paging_on = 1, lk_valid = 0, fill_valid = 0, fence_valid = 0;
  logic fence_rs1_zero = 0, fence_rs2_zero = 0;
  logic [VPN_W-1:0] lk_vpn = '0, fill_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic [1:0] lk_acc = 0, lk_priv = 1, fence_priv = 0;
  logic [2:0] direct_perm = 0, fill_perm = 0;
  logic res_valid, res_fault, walk_req;
  logic [PPN_W-1:0] res_ppn;
  logic [1:0] walk_priv;

  int checks = 0, errors = 0;

  typedef struct { int vpn; int ppn; bit [2:0] perm; } ent_t;
  ent_t mq[$];

  always #10 clk = ~clk;

  prot_tlb #(.ENTRIES(DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W)) dut (.*);

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int find(int vpn);
    foreach (mq[i]) if (mq[i].vpn == vpn) return i;
    return -1;
  endfunction

  function automatic bit allow(bit [2:0] p, int acc);
    return (acc < 3) ? p[acc] : 1'b0;
  endfunction

  task automatic step(string tag);
    bit fl, byp, ev, ef, ew;
    int ep, idx;
    #5;
    fl  = fence_valid && fence_rs1_zero && fence_rs2_zero && fence_priv == 3;
    byp = !paging_on || lk_priv == 3;
    idx = find(int'(lk_vpn));
    ev = 0; ef = 0; ew = 0; ep = 0;
    if (lk_valid) begin
      if (byp) begin
        ev = 1; ep = int'(lk_vpn); ef = !allow(direct_perm, lk_acc);
      end else if (idx >= 0 && !fl) begin
        ev = 1; ep = mq[idx].ppn; ef = !allow(mq[idx].perm, lk_acc);
      end else ew = 1;
    end
    chk(tag, "res_valid", res_valid, ev);
    chk(tag, "res_fault", res_fault, ef);
    chk(tag, "res_ppn", int'(res_ppn), ep);
    chk(tag, "walk_req", walk_req, ew);
    chk("R10", "walk_priv", walk_priv, 1);
    @(posedge clk);
    if (rst_n) begin
      if (fl) mq.delete();
      else if (fill_valid) begin
        int j = find(int'(fill_vpn));
        if (j >= 0) begin
          mq[j].ppn = int'(fill_ppn); mq[j].perm = fill_perm;
        end else begin
          ent_t e;
          e.vpn = int'(fill_vpn); e.ppn = int'(fill_ppn); e.perm = fill_perm;
          if (mq.size() == DEPTH) void'(mq.pop_front());
          mq.push_back(e);
        end
      end
    end
    @(negedge clk);
    lk_valid = 0; fill_valid = 0; fence_valid = 0;
  endtask

  task automatic look(int vpn, int acc, int priv, string tag);
    lk_valid = 1; lk_vpn = VPN_W'(vpn); lk_acc = 2'(acc); lk_priv = 2'(priv);
  endtask

  task automatic fill(int vpn, int ppn, int perm);
    fill_valid = 1; fill_vpn = VPN_W'(vpn); fill_ppn = PPN_W'(ppn); fill_perm = 3'(perm);
  endtask

  task automatic fence(bit z1, bit z2, int priv);
    fence_valid = 1; fence_rs1_zero = z1; fence_rs2_zero = z2; fence_priv = 2'(priv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: empty after reset
    look(5, 0, 1, "R1"); step("R1");
    // R2, R3: eight fills with varied triples
    for (int i = 0; i < 8; i++) begin fill(10 + i, 100 + i, i); step("R2"); end
    for (int i = 0; i < 8; i++)
      for (int a = 0; a < 4; a++) begin look(10 + i, a, (i % 2 == 0) ? 0 : 1, "R3"); step("R3"); end
    // R5: in-place refill of page 10
    fill(10, 555, 7); step("R5");
    look(10, 1, 1, "R5"); step("R5");
    // R4: ninth distinct page evicts oldest (page 10)
    fill(20, 200, 1); step("R4");
    look(10, 0, 1, "R4"); step("R4");
    look(11, 0, 1, "R4"); step("R4");
    look(20, 0, 1, "R4"); step("R4");
    // R7: weak fences keep entries
    fence(0, 1, 3); step("R7"); look(12, 0, 1, "R7"); step("R7");
    fence(1, 0, 3); step("R7"); look(13, 0, 1, "R7"); step("R7");
    fence(1, 1, 1); step("R7"); look(14, 0, 1, "R7"); step("R7");
    fence(1, 1, 0); step("R7"); look(15, 0, 1, "R7"); step("R7");
    // R9: bypass with paging off and in machine mode
    paging_on = 0; direct_perm = 3'b101;
    look(12, 0, 1, "R9"); step("R9");
    look(12, 1, 0, "R9"); step("R9");
    paging_on = 1; direct_perm = 3'b010;
    look(40, 1, 3, "R9"); step("R9");
    look(40, 2, 3, "R9"); step("R9");
    look(12, 0, 1, "R9"); step("R9");
    // R6 + R8: global machine fence with same-cycle lookup and fill
    fence(1, 1, 3); look(12, 0, 1, "R6"); fill(30, 300, 7); step("R6");
    look(30, 0, 1, "R8"); step("R8");
    look(13, 0, 1, "R6"); step("R6");
    // R2: random mixed traffic
    for (int n = 0; n < 600; n++) begin
      paging_on = ($urandom_range(0, 7) != 0);
      direct_perm = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 1) == 1) begin
        int pv = $urandom_range(0, 2);
        look($urandom_range(0, 11), $urandom_range(0, 3), (pv == 2) ? 3 : pv, "R2");
      end
      if ($urandom_range(0, 2) == 0) fill($urandom_range(0, 11), $urandom_range(0, 4000), $urandom_range(0, 7));
      if ($urandom_range(0, 24) == 0) fence($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, $urandom_range(0, 3));
      step("R2");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule